// File: doc/BRIEF.md
# Cascaded Two-Tier Interrupt Aggregator

This block gathers single-cycle event pulses from a serial management bus engine, both its initiating side and its responding side, into a 16-bit primary status word. It also gathers fault pulses into a separate 20-bit fault status word. Every status bit is sticky until software writes a one to it. Each bit has an enable at the same index. The fault tier is qualified by its own enable word and reduced into primary bit 0. The primary tier, gated by a global enable, drives one level-high interrupt line.

Software reaches the registers through a plain synchronous port: a byte address, 32-bit write data, a write strobe, and read data that follows the address within the same cycle. Two write-only injection words let debug software set any status bit in either tier.

Register offsets: 0x00 identity (0x4952_5143), 0x04 revision (0x0001_0000), 0x10 global enable (bit 0), 0x14 primary enable, 0x18 primary status, 0x1C primary injection, 0x20 fault enable, 0x24 fault status, 0x28 fault injection. Any other offset reads as zero.

Top module: `irq_cascade_top`

## Requirements
- R1: After reset, every status bit, every enable bit and the global enable are 0, and `irq_o` is low.
- R2: A pulse on `prim_evt_i[k-1]` sets primary status bit k (k = 1..15) at the next clock edge. The bit stays set until it is cleared by a write of one.
- R3: A write to primary status (0x18) or fault status (0x24) clears exactly the bits written as 1. Bits written as 0 are unchanged.
- R4: When an event and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R5: A pulse on `err_evt_i[j]` sets fault status bit j. Primary bit 0 becomes set one cycle after some fault status bit and its fault enable bit are both 1. A fault bit whose enable is 0 does not set it.
- R6: Once set, primary bit 0 stays set after its cause is gone, until software clears it with a write of one.
- R7: Status bits are recorded whether or not their enable bits are set.
- R8: `irq_o` is high exactly when the global enable is 1 and some primary status bit is set together with its primary enable bit.
- R9: Writing a 1 to a bit of an injection word (0x1C primary, 0x28 fault) sets the matching status bit. Injection words read as 0.
- R10: The identity and revision words return their constants. Unused offsets and reserved bits read as 0: the global enable word shows only bit 0, and the primary enable word shows only bits 15:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr_i | input | 8 | Register byte address |
| reg_wdata_i | input | 32 | Write data |
| reg_wr_i | input | 1 | Write strobe, one cycle per write |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i`, same cycle |
| prim_evt_i | input | 15 | Event pulses for primary bits 15:1 |
| err_evt_i | input | 20 | Fault pulses for fault bits 19:0 |
| irq_o | output | 1 | Level-high interrupt |

## Verification
Primary events are driven as several different bit masks, with the enables both clear and set. This separates recording from interrupt gating. A pulse that coincides with a clear of the same bit checks that the set wins over the clear. Fault pulses are driven once with a non-matching enable and once with a matching one, and the fault bits are then cleared. Together these show that the summary bit depends on the enable and that it stays set after its cause is gone. Injection writes, write masks of zero, and reads of reserved bits tell real register storage apart from decode artefacts.

// File: rtl/irq_cascade_pkg.sv
// Package: shared register offsets and select encoding for the cascaded
// interrupt aggregator. Assumes byte addresses on a 32-bit word grid.
package irq_cascade_pkg;

    localparam int unsigned ADDR_W = 8;
    localparam int unsigned DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFS_IDENT = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_REV   = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_GIE   = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_PEN   = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_PSTAT = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_PINJ  = 8'h1C;
    localparam logic [ADDR_W-1:0] OFS_FEN   = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_FSTAT = 8'h24;
    localparam logic [ADDR_W-1:0] OFS_FINJ  = 8'h28;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_IDENT,
        SEL_REV,
        SEL_GIE,
        SEL_PEN,
        SEL_PSTAT,
        SEL_PINJ,
        SEL_FEN,
        SEL_FSTAT,
        SEL_FINJ
    } reg_sel_e;

    // Map a byte address onto a register select.
    function automatic reg_sel_e addr_to_sel(input logic [ADDR_W-1:0] a);
        case (a)
            OFS_IDENT: return SEL_IDENT;
            OFS_REV:   return SEL_REV;
            OFS_GIE:   return SEL_GIE;
            OFS_PEN:   return SEL_PEN;
            OFS_PSTAT: return SEL_PSTAT;
            OFS_PINJ:  return SEL_PINJ;
            OFS_FEN:   return SEL_FEN;
            OFS_FSTAT: return SEL_FSTAT;
            OFS_FINJ:  return SEL_FINJ;
            default:   return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/irq_status_bank.sv
// Module: one tier of sticky status bits plus a same-width enable word.
// Holds status set by hardware pulses or by injection writes. Status is
// cleared by writing one. A set beats a clear when both hit a bit in one
// cycle. Assumes strobes last exactly one cycle per access.
module irq_status_bank #(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] set_i,
    input  logic [WIDTH-1:0] wdata_i,
    input  logic             clr_wr_i,
    input  logic             inj_wr_i,
    input  logic             en_wr_i,
    output logic [WIDTH-1:0] stat_o,
    output logic [WIDTH-1:0] en_o,
    output logic             pend_o
);

    logic [WIDTH-1:0] stat_q;
    logic [WIDTH-1:0] en_q;
    logic [WIDTH-1:0] clr_mask;
    logic [WIDTH-1:0] inj_mask;
    logic [WIDTH-1:0] stat_d;

    // Build clear and injection masks from the current write.
    always_comb begin
        clr_mask = clr_wr_i ? wdata_i : '0;
        inj_mask = inj_wr_i ? wdata_i : '0;
        stat_d   = (stat_q & ~clr_mask) | set_i | inj_mask;
    end

    // Sticky status register.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_d;
    end

    // Enable register, plain read/write.
    always_ff @(posedge clk) begin
        if (!rst_n)       en_q <= '0;
        else if (en_wr_i) en_q <= wdata_i;
    end

    assign stat_o = stat_q;
    assign en_o   = en_q;
    assign pend_o = |(stat_q & en_q);

endmodule

// File: rtl/irq_reg_decode.sv
// Module: address decode for the register port. Produces one-cycle write
// strobes per register and a combinational read mux. Reserved bits and
// unused offsets read as zero. Assumes PRIM_W and FAULT_W are at most 32.
module irq_reg_decode
    import irq_cascade_pkg::*;
#(
    parameter int unsigned PRIM_W    = 16,
    parameter int unsigned FAULT_W   = 20,
    parameter logic [31:0] IDENT_VAL = 32'h4952_5143,
    parameter logic [31:0] REV_VAL   = 32'h0001_0000
) (
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic               wr_i,
    input  logic               gie_i,
    input  logic [PRIM_W-1:0]  pen_i,
    input  logic [PRIM_W-1:0]  pstat_i,
    input  logic [FAULT_W-1:0] fen_i,
    input  logic [FAULT_W-1:0] fstat_i,
    output logic               gie_wr_o,
    output logic               pen_wr_o,
    output logic               pclr_wr_o,
    output logic               pinj_wr_o,
    output logic               fen_wr_o,
    output logic               fclr_wr_o,
    output logic               finj_wr_o,
    output logic [DATA_W-1:0]  rdata_o
);

    reg_sel_e sel;

    // Decode the address once for both directions.
    always_comb sel = addr_to_sel(addr_i);

    // Per-register write strobes.
    always_comb begin
        gie_wr_o  = wr_i && (sel == SEL_GIE);
        pen_wr_o  = wr_i && (sel == SEL_PEN);
        pclr_wr_o = wr_i && (sel == SEL_PSTAT);
        pinj_wr_o = wr_i && (sel == SEL_PINJ);
        fen_wr_o  = wr_i && (sel == SEL_FEN);
        fclr_wr_o = wr_i && (sel == SEL_FSTAT);
        finj_wr_o = wr_i && (sel == SEL_FINJ);
    end

    // Read mux with zero extension.
    always_comb begin
        rdata_o = '0;
        case (sel)
            SEL_IDENT: rdata_o = IDENT_VAL;
            SEL_REV:   rdata_o = REV_VAL;
            SEL_GIE:   rdata_o[0] = gie_i;
            SEL_PEN:   rdata_o[PRIM_W-1:0] = pen_i;
            SEL_PSTAT: rdata_o[PRIM_W-1:0] = pstat_i;
            SEL_FEN:   rdata_o[FAULT_W-1:0] = fen_i;
            SEL_FSTAT: rdata_o[FAULT_W-1:0] = fstat_i;
            default:   rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/irq_cascade_top.sv
// Module: cascaded two-tier interrupt aggregator. The fault tier, qualified
// by its enables, feeds primary bit 0 through a register stage. The
// primary tier, qualified by its enables and the global enable, drives
// irq_o. Assumes event pulses are synchronous to clk.
module irq_cascade_top
    import irq_cascade_pkg::*;
#(
    parameter int unsigned PRIM_W  = 16,
    parameter int unsigned FAULT_W = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  reg_addr_i,
    input  logic [DATA_W-1:0]  reg_wdata_i,
    input  logic               reg_wr_i,
    output logic [DATA_W-1:0]  reg_rdata_o,
    input  logic [PRIM_W-2:0]  prim_evt_i,
    input  logic [FAULT_W-1:0] err_evt_i,
    output logic               irq_o
);

    localparam int unsigned WMAX = (PRIM_W > FAULT_W) ? PRIM_W : FAULT_W;

    logic               gie_q;
    logic               gie_wr, pen_wr, pclr_wr, pinj_wr;
    logic               fen_wr, fclr_wr, finj_wr;
    logic [PRIM_W-1:0]  prim_stat, prim_en, prim_set;
    logic [FAULT_W-1:0] fault_stat, fault_en;
    logic               prim_pend, fault_pend;
    logic               unused_wdata;

    assign unused_wdata = ^reg_wdata_i[DATA_W-1:WMAX];

    irq_reg_decode #(.PRIM_W(PRIM_W), .FAULT_W(FAULT_W)) u_dec (
        .addr_i    (reg_addr_i),
        .wr_i      (reg_wr_i),
        .gie_i     (gie_q),
        .pen_i     (prim_en),
        .pstat_i   (prim_stat),
        .fen_i     (fault_en),
        .fstat_i   (fault_stat),
        .gie_wr_o  (gie_wr),
        .pen_wr_o  (pen_wr),
        .pclr_wr_o (pclr_wr),
        .pinj_wr_o (pinj_wr),
        .fen_wr_o  (fen_wr),
        .fclr_wr_o (fclr_wr),
        .finj_wr_o (finj_wr),
        .rdata_o   (reg_rdata_o)
    );

    // Global enable flag, bit 0 of its word.
    always_ff @(posedge clk) begin
        if (!rst_n)      gie_q <= 1'b0;
        else if (gie_wr) gie_q <= reg_wdata_i[0];
    end

    irq_status_bank #(.WIDTH(FAULT_W)) u_fault (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (err_evt_i),
        .wdata_i  (reg_wdata_i[FAULT_W-1:0]),
        .clr_wr_i (fclr_wr),
        .inj_wr_i (finj_wr),
        .en_wr_i  (fen_wr),
        .stat_o   (fault_stat),
        .en_o     (fault_en),
        .pend_o   (fault_pend)
    );

    // Primary set vector: hardware events above, fault summary in bit 0.
    assign prim_set = {prim_evt_i, fault_pend};

    irq_status_bank #(.WIDTH(PRIM_W)) u_prim (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (prim_set),
        .wdata_i  (reg_wdata_i[PRIM_W-1:0]),
        .clr_wr_i (pclr_wr),
        .inj_wr_i (pinj_wr),
        .en_wr_i  (pen_wr),
        .stat_o   (prim_stat),
        .en_o     (prim_en),
        .pend_o   (prim_pend)
    );

    // Level interrupt from the primary tier.
    assign irq_o = gie_q & prim_pend;

endmodule

// File: rtl/irq_cascade_chk.sv
// Module: property checker bound into irq_cascade_top. It observes the
// port traffic and both status tiers. It drives nothing.
module irq_cascade_chk
    import irq_cascade_pkg::*;
#(
    parameter int unsigned PRIM_W  = 16,
    parameter int unsigned FAULT_W = 20
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ADDR_W-1:0]  reg_addr_i,
    input logic               reg_wr_i,
    input logic [PRIM_W-2:0]  prim_evt_i,
    input logic [FAULT_W-1:0] err_evt_i,
    input logic [PRIM_W-1:0]  prim_stat,
    input logic [PRIM_W-1:0]  prim_en,
    input logic [FAULT_W-1:0] fault_stat,
    input logic [FAULT_W-1:0] fault_en,
    input logic               gie_q,
    input logic               irq_o
);

    // R3
    prim_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr_i && reg_addr_i == OFS_PSTAT)
        |=> ((prim_stat & $past(prim_stat)) == $past(prim_stat)));

    // R3
    fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr_i && reg_addr_i == OFS_FSTAT)
        |=> ((fault_stat & $past(fault_stat)) == $past(fault_stat)));

    // R2
    prim_event_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prim_evt_i != '0)
        |=> ((prim_stat[PRIM_W-1:1] & $past(prim_evt_i)) == $past(prim_evt_i)));

    // R5
    fault_event_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_evt_i != '0)
        |=> ((fault_stat & $past(err_evt_i)) == $past(err_evt_i)));

    // R5
    summary_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((fault_stat & fault_en) != '0) |=> prim_stat[0]);

    // R8
    irq_needs_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (gie_q && ((prim_stat & prim_en) != '0)));

endmodule

bind irq_cascade_top irq_cascade_chk #(.PRIM_W(PRIM_W), .FAULT_W(FAULT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_addr_i (reg_addr_i),
    .reg_wr_i   (reg_wr_i),
    .prim_evt_i (prim_evt_i),
    .err_evt_i  (err_evt_i),
    .prim_stat  (prim_stat),
    .prim_en    (prim_en),
    .fault_stat (fault_stat),
    .fault_en   (fault_en),
    .gie_q      (gie_q),
    .irq_o      (irq_o)
);

// File: tb/tb_irq_cascade_top.sv
`timescale 1ns/1ps
// Bench: scoreboard style. Driver tasks push expected items into a queue.
// A monitor at the falling edge pops each one and compares it.
module tb_irq_cascade_top;

    localparam logic [7:0] A_IDENT = 8'h00, A_REV = 8'h04, A_HOLE = 8'h08;
    localparam logic [7:0] A_GIE = 8'h10, A_PEN = 8'h14, A_PSTAT = 8'h18;
    localparam logic [7:0] A_PINJ = 8'h1C, A_FEN = 8'h20, A_FSTAT = 8'h24;
    localparam logic [7:0] A_FINJ = 8'h28;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr_i = '0;
    logic [31:0] reg_wdata_i = '0;
    logic        reg_wr_i = 1'b0;
    logic [31:0] reg_rdata_o;
    logic [14:0] prim_evt_i = '0;
    logic [19:0] err_evt_i = '0;
    logic        irq_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } sb_item_t;

    sb_item_t sbq[$];

    always #2.5 clk = ~clk;

    irq_cascade_top dut (
        .clk(clk), .rst_n(rst_n), .reg_addr_i(reg_addr_i),
        .reg_wdata_i(reg_wdata_i), .reg_wr_i(reg_wr_i),
        .reg_rdata_o(reg_rdata_o), .prim_evt_i(prim_evt_i),
        .err_evt_i(err_evt_i), .irq_o(irq_o)
    );

    // Monitor: pop and compare at the falling edge.
    always @(negedge clk) begin
        if (sbq.size() > 0) begin
            sb_item_t it;
            logic [31:0] act;
            it = sbq.pop_front();
            act = it.is_irq ? {31'b0, irq_o} : reg_rdata_o;
            total++;
            if (act !== it.exp) begin
                bad++;
                $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        reg_addr_i = a; reg_wdata_i = d; reg_wr_i = 1'b1;
        @(posedge clk); #1;
        reg_wr_i = 1'b0; reg_wdata_i = '0;
    endtask

    task automatic pulse(input logic [15:0] pmask, input logic [19:0] fmask);
        @(posedge clk); #1;
        prim_evt_i = pmask[15:1]; err_evt_i = fmask;
        @(posedge clk); #1;
        prim_evt_i = '0; err_evt_i = '0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        sb_item_t it;
        @(posedge clk); #1;
        reg_addr_i = a;
        it.is_irq = 1'b0; it.exp = e; it.tag = tag;
        sbq.push_back(it);
        @(negedge clk); #1;
    endtask

    task automatic irq_is(input logic e, input string tag);
        sb_item_t it;
        @(posedge clk); #1;
        it.is_irq = 1'b1; it.exp = {31'b0, e}; it.tag = tag;
        sbq.push_back(it);
        @(negedge clk); #1;
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=complete");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd(A_PSTAT, 32'h0, "R1 primary status");
        rd(A_FSTAT, 32'h0, "R1 fault status");
        rd(A_PEN,   32'h0, "R1 primary enable");
        rd(A_FEN,   32'h0, "R1 fault enable");
        rd(A_GIE,   32'h0, "R1 global enable");
        irq_is(1'b0, "R1 irq low");

        // R10 constants and hole
        rd(A_IDENT, 32'h4952_5143, "R10 identity");
        rd(A_REV,   32'h0001_0000, "R10 revision");
        rd(A_HOLE,  32'h0, "R10 unused offset");

        // R2 / R7 events recorded with enables clear
        pulse(16'h0088, 20'h0);
        rd(A_PSTAT, 32'h0088, "R2 R7 events recorded");
        irq_is(1'b0, "R8 irq off without enables");

        // R3 zero mask then single-bit clear
        wr(A_PSTAT, 32'h0);
        rd(A_PSTAT, 32'h0088, "R3 zero mask no change");
        wr(A_PSTAT, 32'h0008);
        rd(A_PSTAT, 32'h0080, "R3 clears only written bit");

        // R4 set beats clear in the same cycle
        @(posedge clk); #1;
        reg_addr_i = A_PSTAT; reg_wdata_i = 32'h0080; reg_wr_i = 1'b1;
        prim_evt_i = 15'h0080 >> 1;
        @(posedge clk); #1;
        reg_wr_i = 1'b0; prim_evt_i = '0;
        rd(A_PSTAT, 32'h0080, "R4 set wins over clear");
        wr(A_PSTAT, 32'h0080);
        rd(A_PSTAT, 32'h0, "R3 cleared");

        // R8 interrupt gating
        pulse(16'h0020, 20'h0);
        wr(A_PEN, 32'h0020);
        irq_is(1'b0, "R8 global enable off");
        wr(A_GIE, 32'h1);
        irq_is(1'b1, "R8 enabled and pending");
        wr(A_PEN, 32'h0040);
        irq_is(1'b0, "R8 enable mismatch");
        wr(A_PSTAT, 32'h0020);
        rd(A_PSTAT, 32'h0, "R3 primary cleared");

        // R5 fault tier and summary qualification
        pulse(16'h0, 20'h80004);
        rd(A_FSTAT, 32'h0008_0004, "R5 fault bits recorded");
        rd(A_PSTAT, 32'h0, "R5 no summary without fault enable");
        wr(A_FEN, 32'h0000_0004);
        rd(A_PSTAT, 32'h0001, "R5 summary set");

        // R6 summary stays after cause removed
        wr(A_FSTAT, 32'h000F_FFFF);
        rd(A_FSTAT, 32'h0, "R3 fault cleared");
        rd(A_PSTAT, 32'h0001, "R6 summary sticky");
        wr(A_PSTAT, 32'h0001);
        rd(A_PSTAT, 32'h0, "R6 summary cleared by software");

        // R9 injection, plus summary-driven irq
        wr(A_PEN, 32'h0001);
        wr(A_FINJ, 32'h0000_0400);
        rd(A_FSTAT, 32'h0000_0400, "R9 fault injection");
        rd(A_PSTAT, 32'h0, "R5 injected fault not enabled");
        irq_is(1'b0, "R8 no pending summary");
        wr(A_FEN, 32'h0000_0400);
        rd(A_PSTAT, 32'h0001, "R5 summary from injected fault");
        irq_is(1'b1, "R8 irq from summary");
        rd(A_FINJ, 32'h0, "R9 fault injection reads zero");
        wr(A_PINJ, 32'h8000);
        rd(A_PSTAT, 32'h8001, "R9 primary injection");
        rd(A_PINJ, 32'h0, "R9 primary injection reads zero");

        // R10 reserved bits
        wr(A_GIE, 32'hFFFF_FFFF);
        rd(A_GIE, 32'h1, "R10 global enable reserved bits");
        wr(A_PEN, 32'hFFFF_FFFF);
        rd(A_PEN, 32'h0000_FFFF, "R10 primary enable reserved bits");

        repeat (2) @(posedge clk);
        done = 1;
        finish_run();
    end

endmodule